// File: doc/BRIEF.md
# Interrupt Status Bank with Read-to-Clear Registers

This block holds the interrupt state of a serial bus controller. Twelve event sources feed it. Ten of them are one-cycle pulses, and each pulse sets a sticky status bit. The other two are level conditions that the bank copies into status every cycle. A software-written enable mask selects which status bits may raise the single interrupt line. The bank offers a raw view and a masked view of the status.

Software acknowledges events by reading. Each sticky bit has its own clear address: reading it returns the bit's value before the read and clears that bit only. This lets an interrupt handler clear exactly the bits it saw. An event that lands between the handler's status read and its clear reads is then not lost. A combined clear address exists as well; it wipes every sticky bit that is set when it is read.

The abort event also records a cause word. The cause word stays unchanged until the abort bit is acknowledged, so the handler can read it first. The register port is plain: a read strobe, a write strobe, a byte address, write data, and read data. Read data is combinational and is valid in the cycle of the read strobe. The side effect of a read takes place at the clock edge that closes that cycle.

Top module: `irq_status_bank`

## Requirements
- R1: Bit i of `src_evt`, for i in {0,1,3,5,6,7,8,9,10,11}, is a one-cycle event pulse. A pulse sets raw status bit i at the next clock edge, and the bit stays set until one of its clear reads.
- R2: Raw status bits 2 and 4 are level bits. At every edge they load `src_evt[2]` and `src_evt[4]`. No read changes them.
- R3: The mask register at byte offset 0x30 keeps `reg_wdata[11:0]` on a write and reads back zero-extended. Offset 0x34 reads the raw status and offset 0x2c reads the raw status ANDed with the mask. Both are zero-extended.
- R4: The per-bit clear address of the k-th sticky bit (k = 0..9, counted upward from bit 0 over 0,1,3,5,6,7,8,9,10,11) is 0x44 + 4k. A read there returns the bit's prior value in bit 0 and zeros in bits 31:1. The read clears that bit and no other.
- R5: A read of offset 0x40 clears every sticky bit that is set. It returns in bit 0 the OR of the sticky bits before the read, and zeros in bits 31:1.
- R6: When an event pulse and a clear read of the same bit fall in the same cycle, the bit is set after the edge, and the read returns the prior value.
- R7: The abort-cause register at offset 0x80 ORs in `abort_cause_in` on every pulse of event bit 6. It keeps its value until a read of 0x54 or 0x40 clears it. A pulse in the same cycle as such a read leaves only the new cause.
- R8: Writes to any offset other than 0x30 change no status bit, no mask bit and no cause bit.
- R9: `irq` is a register holding the OR of all masked status bits. It changes at the same edge as the status or mask change that causes it.
- R10: Reset (`rst_n` low) clears all status bits, the mask, the abort cause and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 12 | Event pulses (sticky bits) and level conditions (bits 2, 4) |
| abort_cause_in | input | CAUSE_W | Cause bits sampled with event bit 6 |
| reg_rd_en | input | 1 | Read strobe; read side effects happen at the edge |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Registered, active-high interrupt |

## Verification
The hardest situation to create is a collision: an event pulse arriving in the very cycle that a clear read of the same bit retires. The same applies to an abort pulse landing on the read that wipes the cause word. The bench reaches it by driving the read strobe and the event pulse from one task in one cycle. It then checks both the read value and the status afterwards. It also walks all ten per-bit clear addresses in turn against a fully set status, so that a wrong offset or a clear that spills into a neighbour shows up.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int NUM_EVT = 12;
  localparam int ADDR_W  = 8;

  // bit positions of the event sources
  localparam int B_RXUF  = 0;
  localparam int B_RXOF  = 1;
  localparam int B_RXLVL = 2;
  localparam int B_TXOF  = 3;
  localparam int B_TXLVL = 4;
  localparam int B_RDREQ = 5;
  localparam int B_ABORT = 6;
  localparam int B_RXEND = 7;
  localparam int B_BUSACT = 8;
  localparam int B_STOP  = 9;
  localparam int B_START = 10;
  localparam int B_GCALL = 11;

  // level-type bits follow their source and have no clear address
  localparam logic [NUM_EVT-1:0] LEVEL_MASK =
      NUM_EVT'((1 << B_RXLVL) | (1 << B_TXLVL));

  localparam logic [ADDR_W-1:0] OFF_MASKED  = 8'h2c;
  localparam logic [ADDR_W-1:0] OFF_MASK    = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_RAW     = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_CLR_ALL = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_CLR_BASE = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_CAUSE   = 8'h80;

  // clear address of bit idx: one word per sticky bit below it
  function automatic logic [ADDR_W-1:0] clr_offset(input int idx);
    int k;
    k = 0;
    for (int j = 0; j < NUM_EVT; j++) begin
      if (j < idx && !LEVEL_MASK[j]) k++;
    end
    return OFF_CLR_BASE + ADDR_W'(4 * k);
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 16
) (
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_EVT-1:0]  raw_q,
  input  logic [NUM_EVT-1:0]  mask_q,
  input  logic [CAUSE_W-1:0]  cause_q,
  output logic [NUM_EVT-1:0]  clr_vec,
  output logic                mask_we,
  output logic [DATA_W-1:0]   rdata
);

  logic [NUM_EVT-1:0] bit_hit;
  logic               all_hit;

  // one comparator per sticky bit; level bits never decode
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_hit
    if (LEVEL_MASK[i]) begin : g_level
      assign bit_hit[i] = 1'b0;
    end else begin : g_sticky
      assign bit_hit[i] = (addr == clr_offset(i));
    end
  end

  assign all_hit = (addr == OFF_CLR_ALL);
  assign mask_we = wr_en && (addr == OFF_MASK);
  assign clr_vec = rd_en ? (bit_hit | ({NUM_EVT{all_hit}} & ~LEVEL_MASK))
                         : '0;

  always_comb begin
    rdata = '0;
    if (addr == OFF_MASKED) begin
      rdata[NUM_EVT-1:0] = raw_q & mask_q;
    end else if (addr == OFF_MASK) begin
      rdata[NUM_EVT-1:0] = mask_q;
    end else if (addr == OFF_RAW) begin
      rdata[NUM_EVT-1:0] = raw_q;
    end else if (addr == OFF_CAUSE) begin
      rdata[CAUSE_W-1:0] = cause_q;
    end else if (all_hit) begin
      rdata[0] = |(raw_q & ~LEVEL_MASK);
    end else if (|bit_hit) begin
      rdata[0] = |(bit_hit & raw_q);
    end
  end

endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import irq_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] src_evt,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] raw_d,
  output logic [NUM_EVT-1:0] raw_q
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      assign raw_d[i] = src_evt[i];

      // R2
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> raw_q[i] == $past(src_evt[i]));

      // R2
      level_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_vec[i]);
    end else begin : g_sticky
      // a pulse in the clearing cycle wins, so no event is dropped
      assign raw_d[i] = (raw_q[i] & ~clr_vec[i]) | src_evt[i];

      // R6
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[i] |=> raw_q[i]);

      // R4
      clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[i] && !src_evt[i] |=> !raw_q[i]);

      // R1
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q[i] && !clr_vec[i] |=> raw_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause #(
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort_evt,
  input  logic               abort_clr,
  input  logic [CAUSE_W-1:0] cause_in,
  output logic [CAUSE_W-1:0] cause_q
);

  logic [CAUSE_W-1:0] kept;
  logic [CAUSE_W-1:0] fresh;

  assign kept  = abort_clr ? '0 : cause_q;
  assign fresh = abort_evt ? cause_in : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= kept | fresh;
  end

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_clr && !abort_evt |=> $stable(cause_q));

  // R7
  cause_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr && !abort_evt |=> cause_q == '0);

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int CAUSE_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] src_evt,
  input  logic [CAUSE_W-1:0] abort_cause_in,
  input  logic               reg_rd_en,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);

  logic [NUM_EVT-1:0] raw_d;
  logic [NUM_EVT-1:0] raw_q;
  logic [NUM_EVT-1:0] mask_d;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] clr_vec;
  logic [CAUSE_W-1:0] cause_q;
  logic               mask_we;
  logic               irq_q;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_EVT];

  irq_reg_decode #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_decode (
    .rd_en   (reg_rd_en),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .cause_q (cause_q),
    .clr_vec (clr_vec),
    .mask_we (mask_we),
    .rdata   (reg_rdata)
  );

  irq_status_bits u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_evt),
    .clr_vec (clr_vec),
    .raw_d   (raw_d),
    .raw_q   (raw_q)
  );

  irq_abort_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_evt (src_evt[B_ABORT]),
    .abort_clr (clr_vec[B_ABORT]),
    .cause_in  (abort_cause_in),
    .cause_q   (cause_q)
  );

  assign mask_d = mask_we ? reg_wdata[NUM_EVT-1:0] : mask_q;

  // irq is built from next-state values so it lines up with the status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign irq = irq_q;

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == |(raw_q & mask_q));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_addr == OFF_MASK |=> mask_q == $past(reg_wdata[NUM_EVT-1:0]));

  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == OFF_MASK) |=> $stable(mask_q));

endmodule

// File: tb/irq_status_bank_tb.sv
module irq_status_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_evt = '0;
  logic [15:0] abort_cause_in = '0;
  logic        reg_rd_en = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  logic [11:0] lvl = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_status_bank u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_evt        (src_evt),
    .abort_cause_in (abort_cause_in),
    .reg_rd_en      (reg_rd_en),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .irq            (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one bus cycle: strobes and events held for exactly one clock edge
  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [31:0] wd, input logic [11:0] ev,
                     input logic [15:0] c, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = r; reg_wr_en = w; reg_addr = a; reg_wdata = wd;
    src_evt = ev | lvl; abort_cause_in = c;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    src_evt = lvl; abort_cause_in = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cyc(1'b1, 1'b0, a, 32'h0, 12'h0, 16'h0, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d;
    cyc(1'b0, 1'b1, a, wd, 12'h0, 16'h0, d);
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [15:0] c);
    logic [31:0] d;
    cyc(1'b0, 1'b0, 8'h00, 32'h0, ev, c, d);
  endtask

  task automatic set_lvl(input logic [11:0] v);
    logic [31:0] d;
    lvl = v;
    cyc(1'b0, 1'b0, 8'h00, 32'h0, 12'h0, 16'h0, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h34, d); chk("R10 raw after reset", d, 32'h0);
    rd(8'h30, d); chk("R10 mask after reset", d, 32'h0);
    rd(8'h80, d); chk("R10 cause after reset", d, 32'h0);
    chk("R10 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_sticky_mask();
    logic [31:0] d;
    pulse(12'h203, 16'h0);
    repeat (2) @(negedge clk);
    rd(8'h34, d); chk("R1 sticky bits held", d, 32'h203);
    rd(8'h2c, d); chk("R3 masked with zero mask", d, 32'h0);
    chk("R9 irq low when masked off", 32'(irq), 32'h0);
    wr(8'h30, 32'hFFFF_F200);
    chk("R9 irq rises with mask", 32'(irq), 32'h1);
    rd(8'h30, d); chk("R3 mask readback", d, 32'h200);
    rd(8'h2c, d); chk("R3 masked view", d, 32'h200);
  endtask

  task automatic t_clear_one_all();
    logic [31:0] d;
    rd(8'h60, d); chk("R4 clear read returns prior bit", d, 32'h1);
    chk("R9 irq falls after clear", 32'(irq), 32'h0);
    rd(8'h34, d); chk("R4 only targeted bit cleared", d, 32'h003);
    rd(8'h60, d); chk("R4 second clear read returns 0", d, 32'h0);
    rd(8'h40, d); chk("R5 combined clear returns 1", d, 32'h1);
    rd(8'h34, d); chk("R5 combined clear empties", d, 32'h0);
    rd(8'h40, d); chk("R5 combined clear on empty", d, 32'h0);
  endtask

  task automatic t_each_addr();
    int idx_tab[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
    logic [31:0] d;
    logic [31:0] exp_raw;
    pulse(12'hFEB, 16'h0);
    exp_raw = 32'hFEB;
    for (int k = 0; k < 10; k++) begin
      rd(8'(8'h44 + 4 * k), d);
      chk($sformatf("R4 clear addr k=%0d value", k), d, 32'h1);
      exp_raw = exp_raw & ~(32'h1 << idx_tab[k]);
      rd(8'h34, d);
      chk($sformatf("R4 clear addr k=%0d raw", k), d, exp_raw);
    end
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_lvl(12'h014);
    rd(8'h34, d); chk("R2 level bits follow", d, 32'h014);
    rd(8'h40, d); chk("R5 combined clear ignores level bits", d, 32'h0);
    rd(8'h34, d); chk("R2 level bits survive clear", d, 32'h014);
    set_lvl(12'h010);
    rd(8'h34, d); chk("R2 level bit drops with input", d, 32'h010);
    set_lvl(12'h000);
    rd(8'h34, d); chk("R2 level bits gone", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    cyc(1'b1, 1'b0, 8'h64, 32'h0, 12'h400, 16'h0, d);
    chk("R6 clear read in event cycle returns prior", d, 32'h0);
    rd(8'h34, d); chk("R6 event kept over per-bit clear", d, 32'h400);
    pulse(12'h002, 16'h0);
    cyc(1'b1, 1'b0, 8'h40, 32'h0, 12'h001, 16'h0, d);
    chk("R5 combined read value", d, 32'h1);
    rd(8'h34, d); chk("R6 event kept over combined clear", d, 32'h001);
    rd(8'h44, d); chk("R4 cleanup read", d, 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    pulse(12'h040, 16'h0005);
    rd(8'h80, d); chk("R7 first cause", d, 32'h0005);
    pulse(12'h040, 16'h0030);
    rd(8'h80, d); chk("R7 cause accumulates", d, 32'h0035);
    rd(8'h60, d);
    rd(8'h80, d); chk("R7 cause kept over other clear", d, 32'h0035);
    rd(8'h54, d); chk("R7 abort clear returns 1", d, 32'h1);
    rd(8'h80, d); chk("R7 cause cleared", d, 32'h0);
    rd(8'h34, d); chk("R7 abort bit cleared", d, 32'h0);
    pulse(12'h040, 16'h0002);
    cyc(1'b1, 1'b0, 8'h54, 32'h0, 12'h040, 16'h0100, d);
    rd(8'h80, d); chk("R7 new cause kept in clear cycle", d, 32'h0100);
    rd(8'h34, d); chk("R6 abort bit kept in clear cycle", d, 32'h040);
    rd(8'h40, d);
    rd(8'h80, d); chk("R7 combined clear wipes cause", d, 32'h0);
  endtask

  task automatic t_writes();
    logic [31:0] d;
    pulse(12'h080, 16'h0);
    wr(8'h34, 32'h0);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h2c, 32'h0);
    rd(8'h34, d); chk("R8 status unchanged by writes", d, 32'h080);
    wr(8'h80, 32'hFFFF);
    rd(8'h80, d); chk("R8 cause unchanged by write", d, 32'h0);
    rd(8'h30, d); chk("R8 mask unchanged by other writes", d, 32'h200);
    rd(8'h58, d); chk("R4 cleanup read", d, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h30, 32'hFFF);
    chk("R9 irq low with empty status", 32'(irq), 32'h0);
    pulse(12'h008, 16'h0);
    chk("R9 irq on sticky event", 32'(irq), 32'h1);
    rd(8'h4c, d);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    set_lvl(12'h010);
    chk("R9 irq on level bit", 32'(irq), 32'h1);
    set_lvl(12'h000);
    chk("R9 irq follows level", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sticky_mask();
    t_clear_one_all();
    t_each_addr();
    t_level();
    t_race();
    t_abort();
    t_writes();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule